// File: doc/BRIEF.md
# Flash Protection Unlock Sequencer

This block watches every CPU byte and word access to the flash address space and keeps a single protection flag for that memory. The flag is raised or dropped only through a counted sequence. Even-address accesses to a set of authorization windows build up credit in one of two counters. Which counter is used depends on the chip generation. An access to the enable window then tests that credit. A read sets protection and a write clears it. Any access that falls outside every recognised window wipes the accumulated credit.

While protection is on, reads from the certificate windows are answered with a fixed filler pattern instead of the memory contents. Writes into the lowest authorization window (the boot area) never reach memory. On the older generation, probing the enable window repeatedly without credit stops the CPU. The stop is reported on a sticky output that only reset releases. The data-override and write-inhibit flags are combinational for the access on the bus, so the memory datapath can use them in the same cycle. The memory array itself sits outside this block.

All addresses are offsets into the flash region. Word accesses are assumed to be aligned to an even address.

Top module: `flash_prot_seq`

## Requirements
- R1: After reset, `prot_on` and `cpu_freeze` are 0 and no read is overridden.
- R2: Authorization windows are offsets 0x200000–0x20FFFF, 0x212000–0x217FFF and 0x21A000–0x21FFFF. An access there at an even address adds 1 to counter A when `gen_new`=0, or to counter B when `gen_new`=1. An odd-address byte access adds nothing.
- R3: For an access to the enable window 0x1C0000–0x1FFFFF, the pass condition is A≥3 or B≥7. When it passes, a read sets `prot_on` and a write clears it, and both counters return to zero. When it fails, `prot_on` is unchanged.
- R4: Counter B is incremented before the test. A byte access adds 1 and a word read adds 2.
- R5: On the older generation (`gen_new`=0), a failed test at an even address adds 1 to a crash counter. When the crash counter reaches 4, `cpu_freeze` rises and all three counters are zeroed. Odd-address accesses and the newer generation never advance it.
- R6: While `prot_on`=1, a read in 0x210000–0x211FFF or 0x218000–0x219FFF drives `ovr_valid`=1 with `ovr_data`=0x1414 (0x14 on each byte lane) in the same cycle. Writes, and any access while unprotected, give `ovr_valid`=0.
- R7: Any write in 0x200000–0x20FFFF drives `wr_inhibit`=1 in the same cycle, whatever the protection state. No other access asserts it.
- R8: An access outside the authorization, enable and certificate windows zeroes counters A, B and the crash counter. A certificate-window access leaves all of them unchanged.
- R9: A word write is handled as two byte writes: first the even address, then the odd one. It therefore adds 2 to B in the enable window, and at most 1 to the crash counter, which is driven only by the even byte.
- R10: Once `cpu_freeze` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A CPU access is on the bus this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | ADDR_W | Offset of the access inside the flash region |
| gen_new | input | 1 | 1 = newer chip generation (counter B, no crash) |
| ovr_valid | output | 1 | Replace read data with `ovr_data` this cycle |
| ovr_data | output | 16 | Filler data for protected certificate reads |
| wr_inhibit | output | 1 | Block this write from reaching memory |
| prot_on | output | 1 | Current protection flag |
| cpu_freeze | output | 1 | Sticky CPU stop request |

## Verification
The counters are internal, so a wrong count shows up only later, at the enable window. The next enable access either sets or clears protection when it should not, or misses the change. The mistake is therefore visible on `prot_on` one cycle after that enable access. From there it also shows on `ovr_valid` at the next certificate read. A crash counter that runs too fast or too slow moves the rising edge of `cpu_freeze` by one enable probe. The tests therefore stop each sequence exactly one access short of the threshold and one access at it.

// File: rtl/flash_prot_pkg.sv
// Shared types and window decode for the flash protection sequencer.
// Assumes addresses are flash-region offsets zero-extended to 32 bits.
package flash_prot_pkg;

    typedef enum logic [1:0] {
        RG_OTHER  = 2'd0,
        RG_AUTH   = 2'd1,
        RG_ENABLE = 2'd2,
        RG_CERT   = 2'd3
    } region_t;

    localparam logic [31:0] ENA_LO   = 32'h001C_0000;
    localparam logic [31:0] ENA_HI   = 32'h001F_FFFF;
    localparam logic [31:0] BOOT_LO  = 32'h0020_0000;
    localparam logic [31:0] BOOT_HI  = 32'h0020_FFFF;
    localparam logic [31:0] CERTA_LO = 32'h0021_0000;
    localparam logic [31:0] CERTA_HI = 32'h0021_1FFF;
    localparam logic [31:0] AUTHB_LO = 32'h0021_2000;
    localparam logic [31:0] AUTHB_HI = 32'h0021_7FFF;
    localparam logic [31:0] CERTB_LO = 32'h0021_8000;
    localparam logic [31:0] CERTB_HI = 32'h0021_9FFF;
    localparam logic [31:0] AUTHC_LO = 32'h0021_A000;
    localparam logic [31:0] AUTHC_HI = 32'h0021_FFFF;

    // Inclusive range test.
    function automatic logic in_win(input logic [31:0] a, input logic [31:0] lo,
                                    input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Map an offset onto the window class that governs the sequencer.
    function automatic region_t classify(input logic [31:0] a);
        if (in_win(a, ENA_LO, ENA_HI))
            return RG_ENABLE;
        if (in_win(a, BOOT_LO, BOOT_HI) || in_win(a, AUTHB_LO, AUTHB_HI) ||
            in_win(a, AUTHC_LO, AUTHC_HI))
            return RG_AUTH;
        if (in_win(a, CERTA_LO, CERTA_HI) || in_win(a, CERTB_LO, CERTB_HI))
            return RG_CERT;
        return RG_OTHER;
    endfunction

endpackage

// File: rtl/fp_window_decode.sv
// Address window decoder.
// Classifies the bus offset into a sequencer region and flags the boot area.
// Purely combinational; assumes ADDR_W <= 32.
module fp_window_decode
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic              boot_hit
);

    logic [31:0] addr32;

    // Widen the offset and decode it.
    always_comb begin
        addr32   = 32'(addr);
        region   = classify(addr32);
        boot_hit = in_win(addr32, BOOT_LO, BOOT_HI);
    end

endmodule

// File: rtl/fp_seq_core.sv
// Authorization counters, protection flag and crash detector.
// Each bus access is applied as one or two byte-lane steps: a word write is
// split into an even-byte step followed by an odd-byte step; every other
// access is a single step. The steps are chained combinationally and the
// result is registered once per cycle. Assumes word accesses are aligned.
module fp_seq_core
    import flash_prot_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int CRASH_W   = 3,
    parameter int A_THR     = 3,
    parameter int B_THR     = 7,
    parameter int CRASH_LIM = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acc_valid,
    input  logic    is_write,
    input  logic    is_word,
    input  logic    addr_lsb,
    input  logic    gen_new,
    input  region_t region,
    output logic    prot_on,
    output logic    freeze
);

    localparam int LANES = 2;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt_a;
        logic [CNT_W-1:0]   cnt_b;
        logic [CRASH_W-1:0] crash;
        logic               prot;
        logic               frz;
    } seq_state_t;

    // Saturating add for the authorization counters.
    function automatic logic [CNT_W-1:0] add_cnt(input logic [CNT_W-1:0] v,
                                                  input logic [1:0] inc);
        logic [CNT_W:0] sum;
        sum = {1'b0, v} + (CNT_W+1)'(inc);
        return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    endfunction

    // Saturating increment for the crash counter.
    function automatic logic [CRASH_W-1:0] add_crash(input logic [CRASH_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // One byte-lane step of the sequencer.
    function automatic seq_state_t step(input seq_state_t s, input region_t rg,
                                        input logic rd, input logic even,
                                        input logic [1:0] inc, input logic newgen);
        seq_state_t n;
        n = s;
        case (rg)
            RG_AUTH: begin
                if (even) begin
                    if (newgen) n.cnt_b = add_cnt(s.cnt_b, 2'd1);
                    else        n.cnt_a = add_cnt(s.cnt_a, 2'd1);
                end
            end
            RG_ENABLE: begin
                n.cnt_b = add_cnt(s.cnt_b, inc);
                if ((s.cnt_a >= CNT_W'(A_THR)) || (n.cnt_b >= CNT_W'(B_THR))) begin
                    n.prot  = rd;
                    n.cnt_a = '0;
                    n.cnt_b = '0;
                end else if (!newgen) begin
                    if (even) n.crash = add_crash(s.crash);
                    if (n.crash >= CRASH_W'(CRASH_LIM)) begin
                        n.frz   = 1'b1;
                        n.cnt_a = '0;
                        n.cnt_b = '0;
                        n.crash = '0;
                    end
                end
            end
            RG_CERT: ;
            default: begin
                n.cnt_a = '0;
                n.cnt_b = '0;
                n.crash = '0;
            end
        endcase
        return n;
    endfunction

    seq_state_t state_q;
    seq_state_t chain [0:LANES];
    logic [1:0] step_inc;

    assign chain[0]  = state_q;
    // A word read advances counter B by two in a single step.
    assign step_inc  = (is_word && !is_write) ? 2'd2 : 2'd1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_act;
        logic lane_even;
        // Lane 0 carries every access; lane 1 only the odd byte of a word write.
        assign lane_act  = acc_valid && ((g == 0) || (is_write && is_word));
        assign lane_even = (g == 0) ? !addr_lsb : 1'b0;
        assign chain[g+1] = lane_act
                          ? step(chain[g], region, !is_write, lane_even, step_inc, gen_new)
                          : chain[g];
    end

    // Register the result of the lane chain.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= chain[LANES];
    end

    assign prot_on = state_q.prot;
    assign freeze  = state_q.frz;

endmodule

// File: rtl/fp_bus_override.sv
// Same-cycle datapath controls: read-data override for protected certificate
// reads and write inhibit for the boot area. Combinational only.
module fp_bus_override
    import flash_prot_pkg::*;
#(
    parameter logic [7:0] FILL_BYTE = 8'h14
) (
    input  logic        acc_valid,
    input  logic        is_write,
    input  region_t     region,
    input  logic        boot_hit,
    input  logic        prot_on,
    output logic        ovr_valid,
    output logic [15:0] ovr_data,
    output logic        wr_inhibit
);

    // Decide override and inhibit for the access now on the bus.
    always_comb begin
        ovr_valid  = acc_valid && !is_write && prot_on && (region == RG_CERT);
        ovr_data   = {2{FILL_BYTE}};
        wr_inhibit = acc_valid && is_write && boot_hit;
    end

endmodule

// File: rtl/flash_prot_seq.sv
// Flash protection unlock sequencer, top level.
// Snoops CPU accesses to the flash region, keeps the protection flag,
// overrides protected certificate reads, blocks boot-area writes and raises
// a sticky CPU freeze on the older generation. Synchronous active-low reset.
module flash_prot_seq
    import flash_prot_pkg::*;
#(
    parameter int         ADDR_W    = 22,
    parameter int         CNT_W     = 4,
    parameter int         CRASH_W   = 3,
    parameter int         A_THR     = 3,
    parameter int         B_THR     = 7,
    parameter int         CRASH_LIM = 4,
    parameter logic [7:0] FILL_BYTE = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              gen_new,
    output logic              ovr_valid,
    output logic [15:0]       ovr_data,
    output logic              wr_inhibit,
    output logic              prot_on,
    output logic              cpu_freeze
);

    region_t region;
    logic    boot_hit;

    fp_window_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .region   (region),
        .boot_hit (boot_hit)
    );

    fp_seq_core #(
        .CNT_W     (CNT_W),
        .CRASH_W   (CRASH_W),
        .A_THR     (A_THR),
        .B_THR     (B_THR),
        .CRASH_LIM (CRASH_LIM)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .is_write  (bus_write),
        .is_word   (bus_word),
        .addr_lsb  (bus_addr[0]),
        .gen_new   (gen_new),
        .region    (region),
        .prot_on   (prot_on),
        .freeze    (cpu_freeze)
    );

    fp_bus_override #(.FILL_BYTE(FILL_BYTE)) u_ovr (
        .acc_valid  (bus_valid),
        .is_write   (bus_write),
        .region     (region),
        .boot_hit   (boot_hit),
        .prot_on    (prot_on),
        .ovr_valid  (ovr_valid),
        .ovr_data   (ovr_data),
        .wr_inhibit (wr_inhibit)
    );

endmodule

// File: rtl/flash_prot_seq_chk.sv
// Property checker for flash_prot_seq, attached with bind below.
// Decodes the enable window on its own, independent of the design decoder.
module flash_prot_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_word,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              gen_new,
    input logic              ovr_valid,
    input logic [15:0]       ovr_data,
    input logic              wr_inhibit,
    input logic              prot_on,
    input logic              cpu_freeze
);

    logic ena_hit;
    logic rst_q;

    // Independent enable-window decode.
    assign ena_hit = (32'(bus_addr) >= 32'h001C_0000) && (32'(bus_addr) <= 32'h001F_FFFF);

    // Remember the previous reset level to spot the release cycle.
    always_ff @(posedge clk) rst_q <= rst_n;

    // R1: first cycle out of reset shows a clear state.
    always @(posedge clk) begin
        if (rst_n && (rst_q === 1'b0))
            a_r1_reset_clear: assert (!prot_on && !cpu_freeze);
    end

    a_r3_set_by_enable_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(bus_valid && !bus_write && ena_hit));

    a_r3_clear_by_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(bus_valid && bus_write && ena_hit));

    a_r6_override_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> (prot_on && bus_valid && !bus_write && ovr_data == 16'h1414));

    a_r7_inhibit_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (bus_valid && bus_write));

    a_r10_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_freeze |=> cpu_freeze);

    a_r5_freeze_old_gen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_freeze) |-> $past(!gen_new && bus_valid && ena_hit));

endmodule

bind flash_prot_seq flash_prot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_prot_seq_test.sv
`timescale 1ns/1ps
// Directed bench for flash_prot_seq: one task per scenario.
module flash_prot_seq_test;

    localparam int ADDR_W = 22;
    localparam logic [ADDR_W-1:0] A_AUTH0 = 22'h20_0010;
    localparam logic [ADDR_W-1:0] A_AUTH1 = 22'h21_5000;
    localparam logic [ADDR_W-1:0] A_AUTH2 = 22'h21_A100;
    localparam logic [ADDR_W-1:0] A_ENA   = 22'h1C_0000;
    localparam logic [ADDR_W-1:0] A_CERT0 = 22'h21_0100;
    localparam logic [ADDR_W-1:0] A_CERT1 = 22'h21_8004;
    localparam logic [ADDR_W-1:0] A_OTHER = 22'h00_0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic              bus_word = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              gen_new = 1'b0;
    logic              ovr_valid;
    logic [15:0]       ovr_data;
    logic              wr_inhibit;
    logic              prot_on;
    logic              cpu_freeze;

    int n_checks = 0;
    int n_fails  = 0;
    logic        s_ovr;
    logic [15:0] s_ovr_data;
    logic        s_inh;

    always #10 clk = ~clk;

    flash_prot_seq #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .gen_new(gen_new),
        .ovr_valid(ovr_valid), .ovr_data(ovr_data), .wr_inhibit(wr_inhibit),
        .prot_on(prot_on), .cpu_freeze(cpu_freeze)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic gen);
        @(negedge clk);
        rst_n = 1'b0;
        bus_valid = 1'b0;
        gen_new = gen;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access: outputs sampled mid-cycle, state settled after the edge.
    task automatic acc(input logic wr, input logic word, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_word  = word;
        bus_addr  = a;
        #5;
        s_ovr      = ovr_valid;
        s_ovr_data = ovr_data;
        s_inh      = wr_inhibit;
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    task automatic auth_reads(input int n, input logic odd);
        for (int i = 0; i < n; i++) begin
            case (i % 3)
                0:       acc(1'b0, 1'b0, A_AUTH0 | 22'(odd));
                1:       acc(1'b0, 1'b0, A_AUTH1 | 22'(odd));
                default: acc(1'b0, 1'b0, A_AUTH2 | 22'(odd));
            endcase
        end
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        #1;
        check(16'(prot_on), 16'd0, "R1 prot_on after reset");
        check(16'(cpu_freeze), 16'd0, "R1 cpu_freeze after reset");
        acc(1'b0, 1'b0, A_CERT0);
        check(16'(s_ovr), 16'd0, "R1 R6 no override while unprotected");
    endtask

    task automatic t_old_auth;
        do_reset(1'b0);
        auth_reads(2, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R3 two A credits do not pass");
        do_reset(1'b0);
        auth_reads(3, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R2 R3 three A credits then read sets");
        acc(1'b0, 1'b1, A_CERT0);
        check(16'(s_ovr), 16'd1, "R6 protected word read overridden");
        check(s_ovr_data, 16'h1414, "R6 filler pattern");
        acc(1'b0, 1'b0, A_CERT1);
        check(16'(s_ovr), 16'd1, "R6 second certificate window");
        acc(1'b1, 1'b0, A_CERT0);
        check(16'(s_ovr), 16'd0, "R6 write not overridden");
        acc(1'b1, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R3 counters zeroed after set");
        auth_reads(3, 1'b0);
        acc(1'b1, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R3 write clears");
        acc(1'b0, 1'b0, A_CERT0);
        check(16'(s_ovr), 16'd0, "R6 no override after clear");
    endtask

    task automatic t_odd_auth;
        do_reset(1'b0);
        auth_reads(3, 1'b1);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R2 odd authorization reads ignored");
        do_reset(1'b1);
        auth_reads(3, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R2 new gen credits go to B not A");
    endtask

    task automatic t_new_b;
        do_reset(1'b1);
        auth_reads(6, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R4 B=6 plus byte read reaches 7");
        do_reset(1'b1);
        auth_reads(5, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R4 B=6 below threshold");
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R4 second enable byte read reaches 7");
        do_reset(1'b1);
        auth_reads(5, 1'b0);
        acc(1'b0, 1'b1, A_ENA);
        check(16'(prot_on), 16'd1, "R4 word read adds two");
    endtask

    task automatic t_crash;
        do_reset(1'b0);
        for (int i = 0; i < 3; i++) acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd0, "R5 three probes no freeze");
        acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd1, "R5 fourth probe freezes");
        acc(1'b0, 1'b0, A_OTHER);
        auth_reads(2, 1'b0);
        check(16'(cpu_freeze), 16'd1, "R10 freeze sticky");
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) acc(1'b0, 1'b0, A_ENA | 22'd1);
        check(16'(cpu_freeze), 16'd0, "R5 odd probes no crash count");
        check(16'(prot_on), 16'd0, "R4 six odd probes below 7");
        acc(1'b0, 1'b0, A_ENA | 22'd1);
        check(16'(prot_on), 16'd1, "R4 seventh odd probe sets");
        do_reset(1'b0);
        for (int i = 0; i < 3; i++) acc(1'b0, 1'b1, A_ENA);
        check(16'(cpu_freeze), 16'd0, "R5 three word probes no freeze");
        acc(1'b0, 1'b1, A_ENA);
        check(16'(prot_on), 16'd1, "R4 R5 fourth word probe reaches B=8");
        check(16'(cpu_freeze), 16'd0, "R5 B pass wins over crash");
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd0, "R5 new generation never freezes");
    endtask

    task automatic t_window_reset;
        do_reset(1'b0);
        auth_reads(2, 1'b0);
        acc(1'b0, 1'b0, A_OTHER);
        auth_reads(1, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd0, "R8 unrelated access wipes credit");
        do_reset(1'b0);
        auth_reads(2, 1'b0);
        acc(1'b0, 1'b0, A_CERT1);
        auth_reads(1, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R8 certificate access keeps credit");
        do_reset(1'b0);
        for (int i = 0; i < 3; i++) acc(1'b0, 1'b0, A_ENA);
        acc(1'b0, 1'b0, A_OTHER);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd0, "R8 unrelated access wipes crash count");
    endtask

    task automatic t_word_write;
        do_reset(1'b1);
        auth_reads(7, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        auth_reads(5, 1'b0);
        acc(1'b1, 1'b0, A_ENA);
        check(16'(prot_on), 16'd1, "R9 byte write from B=5 stays set");
        do_reset(1'b1);
        auth_reads(7, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        auth_reads(5, 1'b0);
        acc(1'b1, 1'b1, A_ENA);
        check(16'(prot_on), 16'd0, "R9 word write from B=5 clears");
        do_reset(1'b0);
        acc(1'b1, 1'b1, A_ENA);
        acc(1'b1, 1'b1, A_ENA);
        acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd0, "R9 word write counts one crash");
        acc(1'b0, 1'b0, A_ENA);
        check(16'(cpu_freeze), 16'd1, "R9 R5 crash reaches four");
    endtask

    task automatic t_inhibit;
        do_reset(1'b0);
        acc(1'b1, 1'b0, 22'h20_0000);
        check(16'(s_inh), 16'd1, "R7 boot write low edge");
        acc(1'b1, 1'b0, 22'h20_FFFF);
        check(16'(s_inh), 16'd1, "R7 boot write high edge");
        acc(1'b1, 1'b0, 22'h21_0000);
        check(16'(s_inh), 16'd0, "R7 just above boot area");
        acc(1'b0, 1'b0, 22'h20_0000);
        check(16'(s_inh), 16'd0, "R7 read not inhibited");
        auth_reads(3, 1'b0);
        acc(1'b0, 1'b0, A_ENA);
        acc(1'b1, 1'b1, 22'h20_0004);
        check(16'(s_inh), 16'd1, "R7 inhibited while protected");
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_old_auth();
        t_odd_auth();
        t_new_b();
        t_crash();
        t_window_reset();
        t_word_write();
        t_inhibit();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule